// File: doc/BRIEF.md
# Prioritised 64-Source Interrupt Controller

The block collects 64 level-sensitive interrupt requests and offers the CPU one winner at a time. Each source has an 8-bit priority level. A source takes part in arbitration only while its level is nonzero. A source is active when it is requested or forced, takes part, and is not masked. The winner is the active source with the largest level, and on equal levels the higher-numbered source wins. The block drives that level and a vector equal to the source number plus 64 to the CPU. When nothing is active it drives level 0 and vector 24.

Software reaches the block over a simple register bus with an 8-bit byte offset, a write strobe and a 32-bit combinational read path. The 64-bit request (pending), mask and force words each appear as two 32-bit halves, with the upper half at the lower offset. One byte-wide command sets mask bits and another clears them, either one bit or all bits at once. A read-only location returns the vector currently on offer.

Top module: `intc64_top`

## Requirements
- R1: After reset the mask is all ones; pending, force, enables and levels are all zero; cpuLevel is 0 and cpuVector is 24.
- R2: A write to level offset 0x40+n with a nonzero wdata[7:0] enables source n. Writing zero disables it, and a disabled source is never selected.
- R3: A source is active exactly when (pending OR forced) AND enabled AND NOT masked. A forced source behaves like a requested one.
- R4: The selected source is the active one with the largest level. On equal levels the highest source number wins.
- R5: cpuVector is the selected source number plus 64 and cpuLevel is its level. With no active source, cpuLevel is 0 and cpuVector is 24.
- R6: Pending captures req on every clock. It reads at 0x00 (bits 63:32) and 0x04 (bits 31:0). Bus writes to those offsets are ignored.
- R7: The mask is read and written at 0x08 (bits 63:32) and 0x0C (bits 31:0). The force word is read and written at 0x10 and 0x14 in the same way. A mask bit of 1 blocks its source.
- R8: A write to 0x1C sets all mask bits if wdata[6] is 1. Otherwise it sets only the mask bit numbered wdata[5:0].
- R9: A write to 0x1D clears all mask bits if wdata[6] is 1. Otherwise it clears only the mask bit numbered wdata[5:0].
- R10: A read of 0xE0 returns the current cpuVector in bits 7:0.
- R11: A read of 0x40+n returns the level of source n in bits 7:0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 64 | Interrupt request lines, one per source |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| cpuLevel | output | 8 | Level of the selected source, 0 if none |
| cpuVector | output | 8 | Vector of the selected source, 24 if none |

## Verification
Directed sequences separate the cases one at a time. They show that a request with a zero level stays invisible and that equal levels resolve to the higher source number. They also show that a higher level on a lower number overrides the tie, and that forcing stands in for a request. Whole-mask commands and single-bit commands are tried against each other, so a stray bit or a wrong all-bits decode shows up in both the outputs and the mask read-back. A long random phase then mixes sparse request patterns, small level values that make ties frequent, and mask and force writes. The outputs are compared against a behavioural model on every clock, which catches errors in scan order, comparison direction and enable tracking.

// File: rtl/intc64_pkg.sv
package intc64_pkg;
  localparam int DATA_W = 32;
  localparam int SRC_IDX_W = 6;

  typedef struct packed {
    logic wrMaskHi;
    logic wrMaskLo;
    logic wrForceHi;
    logic wrForceLo;
    logic wrLevel;
    logic setMask;
    logic clrMask;
    logic [SRC_IDX_W-1:0] levelIdx;
  } strobe_t;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_PEND_HI,
    RD_PEND_LO,
    RD_MASK_HI,
    RD_MASK_LO,
    RD_FORCE_HI,
    RD_FORCE_LO,
    RD_LEVEL,
    RD_VECTOR
  } rdsel_t;
endpackage

// File: rtl/intc64_ctrl.sv
module intc64_ctrl
  import intc64_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output rdsel_t            rdSel,
  output logic [SRC_IDX_W-1:0] rdIdx
);
  logic isLevelWin;

  assign isLevelWin = (addr[ADDR_W-1:SRC_IDX_W] == 1);
  assign rdIdx = addr[SRC_IDX_W-1:0];

  always_comb begin
    stb = '0;
    stb.levelIdx = addr[SRC_IDX_W-1:0];
    if (wrEn) begin
      if (isLevelWin) stb.wrLevel = 1'b1;
      else begin
        case (addr)
          8'h08: stb.wrMaskHi = 1'b1;
          8'h0C: stb.wrMaskLo = 1'b1;
          8'h10: stb.wrForceHi = 1'b1;
          8'h14: stb.wrForceLo = 1'b1;
          8'h1C: stb.setMask = 1'b1;
          8'h1D: stb.clrMask = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (isLevelWin) rdSel = RD_LEVEL;
    else begin
      case (addr)
        8'h00: rdSel = RD_PEND_HI;
        8'h04: rdSel = RD_PEND_LO;
        8'h08: rdSel = RD_MASK_HI;
        8'h0C: rdSel = RD_MASK_LO;
        8'h10: rdSel = RD_FORCE_HI;
        8'h14: rdSel = RD_FORCE_LO;
        8'hE0: rdSel = RD_VECTOR;
        default: rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/intc64_arbiter.sv
module intc64_arbiter #(
  parameter int NUM_SRC = 64,
  parameter int LVL_W = 8,
  parameter int VEC_W = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_NONE = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_SRC-1:0] active,
  input  logic [LVL_W-1:0] levels [NUM_SRC],
  output logic [LVL_W-1:0] cpuLevel,
  output logic [VEC_W-1:0] cpuVector
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [LVL_W-1:0] bestLvl;
  logic [IDX_W-1:0] bestIdx;
  logic             found;

  // Upward scan with >=: a later (higher-numbered) equal level replaces the earlier one.
  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active[i] && (levels[i] >= bestLvl)) begin
        bestLvl = levels[i];
        bestIdx = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign cpuLevel = found ? bestLvl : '0;
  assign cpuVector = found ? (VEC_W'(VEC_BASE) + VEC_W'(bestIdx)) : VEC_W'(VEC_NONE);

  // R5: idle pairing of level and vector
  a_r5_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> (cpuLevel == '0 && cpuVector == VEC_W'(VEC_NONE)));
  // R5: a selection always lands in the source vector window
  a_r5_vector_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuLevel != '0) |-> (cpuVector >= VEC_W'(VEC_BASE)));
endmodule

// File: rtl/intc64_datapath.sv
module intc64_datapath
  import intc64_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int LVL_W = 8,
  parameter int VEC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  strobe_t            stb,
  input  logic [DATA_W-1:0]  wdata,
  input  rdsel_t             rdSel,
  input  logic [SRC_IDX_W-1:0] rdIdx,
  input  logic [LVL_W-1:0]   cpuLevel,
  input  logic [VEC_W-1:0]   cpuVector,
  output logic [NUM_SRC-1:0] active,
  output logic [LVL_W-1:0]   levels [NUM_SRC],
  output logic [DATA_W-1:0]  rdata
);
  localparam int HALF = NUM_SRC / 2;

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] force_r;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] oneBit;

  assign oneBit = NUM_SRC'(1) << wdata[SRC_IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else pend <= req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '1;
    else if (stb.wrMaskHi) mask[NUM_SRC-1:HALF] <= wdata[HALF-1:0];
    else if (stb.wrMaskLo) mask[HALF-1:0] <= wdata[HALF-1:0];
    else if (stb.setMask) mask <= wdata[6] ? '1 : (mask | oneBit);
    else if (stb.clrMask) mask <= wdata[6] ? '0 : (mask & ~oneBit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_r <= '0;
    else if (stb.wrForceHi) force_r[NUM_SRC-1:HALF] <= wdata[HALF-1:0];
    else if (stb.wrForceLo) force_r[HALF-1:0] <= wdata[HALF-1:0];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        levels[g] <= '0;
        en[g] <= 1'b0;
      end else if (stb.wrLevel && stb.levelIdx == SRC_IDX_W'(g)) begin
        levels[g] <= wdata[LVL_W-1:0];
        en[g] <= |wdata[LVL_W-1:0];
      end
    end
    assign active[g] = (pend[g] | force_r[g]) & en[g] & ~mask[g];
  end

  always_comb begin
    case (rdSel)
      RD_PEND_HI:  rdata = pend[NUM_SRC-1:HALF];
      RD_PEND_LO:  rdata = pend[HALF-1:0];
      RD_MASK_HI:  rdata = mask[NUM_SRC-1:HALF];
      RD_MASK_LO:  rdata = mask[HALF-1:0];
      RD_FORCE_HI: rdata = force_r[NUM_SRC-1:HALF];
      RD_FORCE_LO: rdata = force_r[HALF-1:0];
      RD_LEVEL:    rdata = DATA_W'(levels[rdIdx]);
      RD_VECTOR:   rdata = DATA_W'(cpuVector);
      default:     rdata = '0;
    endcase
  end

  // R8: all-bits set command
  a_r8_set_all: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.setMask && wdata[6]) |=> (mask == '1));
  // R9: all-bits clear command
  a_r9_clr_all: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.clrMask && wdata[6]) |=> (mask == '0));
  // R2: writing a zero level withdraws the source
  a_r2_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrLevel && wdata[LVL_W-1:0] == '0) |=> !active[$past(stb.levelIdx)]);
  // R4: the offered level is the level stored for the offered source
  a_r4_level_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuLevel != '0) |-> (levels[cpuVector[SRC_IDX_W-1:0]] == cpuLevel));
  // R3: the offered source is an active one
  a_r3_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuLevel != '0) |-> active[cpuVector[SRC_IDX_W-1:0]]);
endmodule

// File: rtl/intc64_top.sv
module intc64_top
  import intc64_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int LVL_W = 8,
  parameter int VEC_W = 8,
  parameter int ADDR_W = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_NONE = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [LVL_W-1:0]   cpuLevel,
  output logic [VEC_W-1:0]   cpuVector
);
  strobe_t stb;
  rdsel_t  rdSel;
  logic [SRC_IDX_W-1:0] rdIdx;
  logic [NUM_SRC-1:0] active;
  logic [LVL_W-1:0] levels [NUM_SRC];

  intc64_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn(wrEn), .addr(addr), .stb(stb), .rdSel(rdSel), .rdIdx(rdIdx)
  );

  intc64_datapath #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W)) uData (
    .clk(clk), .rst_n(rst_n), .req(req), .stb(stb), .wdata(wdata),
    .rdSel(rdSel), .rdIdx(rdIdx), .cpuLevel(cpuLevel), .cpuVector(cpuVector),
    .active(active), .levels(levels), .rdata(rdata)
  );

  intc64_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W),
                   .VEC_BASE(VEC_BASE), .VEC_NONE(VEC_NONE)) uArb (
    .clk(clk), .rst_n(rst_n), .active(active), .levels(levels),
    .cpuLevel(cpuLevel), .cpuVector(cpuVector)
  );
endmodule

// File: tb/tb_intc64_top.sv
module tb_intc64_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  cpuLevel;
  logic [7:0]  cpuVector;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  bit done = 1'b0;

  intc64_top dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cpuLevel(cpuLevel), .cpuVector(cpuVector)
  );

  always #5 clk = ~clk;

  // Behavioural reference state
  bit [63:0] mPend, mMask, mForce, mEn;
  int mLvl [64];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPend <= '0; mMask <= '1; mForce <= '0; mEn <= '0;
      for (int i = 0; i < 64; i++) mLvl[i] <= 0;
    end else begin
      mPend <= req;
      if (wrEn) begin
        if (addr >= 8'h40 && addr <= 8'h7F) begin
          mLvl[addr - 8'h40] <= int'(wdata[7:0]);
          mEn[addr - 8'h40] <= (wdata[7:0] != 0);
        end
        case (addr)
          8'h08: mMask[63:32] <= wdata;
          8'h0C: mMask[31:0] <= wdata;
          8'h10: mForce[63:32] <= wdata;
          8'h14: mForce[31:0] <= wdata;
          8'h1C: if (wdata[6]) mMask <= '1; else mMask[wdata[5:0]] <= 1'b1;
          8'h1D: if (wdata[6]) mMask <= '0; else mMask[wdata[5:0]] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  function automatic void expected(output int lvl, output int vec);
    int best = -1;
    int bestLv = 0;
    for (int i = 0; i < 64; i++) begin
      if ((mPend[i] || mForce[i]) && mEn[i] && !mMask[i] && mLvl[i] >= bestLv) begin
        bestLv = mLvl[i];
        best = i;
      end
    end
    lvl = (best < 0) ? 0 : bestLv;
    vec = (best < 0) ? 24 : best + 64;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison (R4 / R5)
  always @(posedge clk) begin
    int el, ev;
    #2;
    if (rst_n && checking) begin
      expected(el, ev);
      check("R4 cycle level", longint'(cpuLevel), longint'(el));
      check("R5 cycle vector", longint'(cpuVector), longint'(ev));
    end
  end

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, longint'(rdata), longint'(exp));
  endtask

  task automatic outChk(input string tag, input int lvl, input int vec);
    @(negedge clk);
    check({tag, " level"}, longint'(cpuLevel), longint'(lvl));
    check({tag, " vector"}, longint'(cpuVector), longint'(vec));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checking = 1'b1;
    // R1 reset state
    outChk("R1 reset", 0, 24);
    rdChk("R1 mask hi", 8'h08, 32'hFFFF_FFFF);
    rdChk("R1 mask lo", 8'h0C, 32'hFFFF_FFFF);
    rdChk("R1 pend lo", 8'h04, 32'h0);
    rdChk("R1 force hi", 8'h10, 32'h0);
    rdChk("R1 level 0x45", 8'h45, 32'h0);
    // R2: request with zero level stays hidden
    @(negedge clk); req[5] = 1'b1;
    busWr(8'h1D, 32'd5);
    outChk("R2 zero level hidden", 0, 24);
    busWr(8'h45, 32'd3);
    outChk("R5 source 5 level 3", 3, 69);
    // R4 tie -> higher source number
    @(negedge clk); req[9] = 1'b1;
    busWr(8'h1D, 32'd9);
    busWr(8'h49, 32'd3);
    outChk("R4 tie high index", 3, 73);
    // R4 higher level on lower source wins
    @(negedge clk); req[2] = 1'b1;
    busWr(8'h1D, 32'd2);
    busWr(8'h42, 32'd6);
    outChk("R4 higher level", 6, 66);
    busWr(8'h42, 32'd0);
    outChk("R2 zero level withdraws", 3, 73);
    // R11 level readback, unmapped read
    rdChk("R11 level 0x49", 8'h49, 32'd3);
    rdChk("R11 unmapped", 8'h30, 32'd0);
    // R6 pending read and write ignored
    busWr(8'h04, 32'hFFFF_FFFF);
    rdChk("R6 pend lo ignores write", 8'h04, 32'h0000_0224);
    rdChk("R6 pend hi", 8'h00, 32'h0);
    // R8 mask all
    busWr(8'h1C, 32'h40);
    outChk("R8 mask all", 0, 24);
    rdChk("R8 mask lo", 8'h0C, 32'hFFFF_FFFF);
    // R9 clear all, R8 single set
    busWr(8'h1D, 32'h40);
    rdChk("R9 clear all hi", 8'h08, 32'h0);
    busWr(8'h1C, 32'd9);
    rdChk("R8 single set", 8'h0C, 32'h0000_0200);
    outChk("R8 masked 9 leaves 5", 3, 69);
    busWr(8'h1D, 32'd9);
    rdChk("R9 single clear", 8'h0C, 32'h0);
    // R3 force replaces request
    @(negedge clk); req = '0;
    busWr(8'h14, 32'h0000_0200);
    outChk("R3 forced source", 3, 73);
    rdChk("R7 force lo", 8'h14, 32'h0000_0200);
    rdChk("R10 vector read", 8'hE0, 32'd73);
    // R7 mask halves
    busWr(8'h08, 32'hA5A5_0000);
    rdChk("R7 mask hi", 8'h08, 32'hA5A5_0000);
    busWr(8'h0C, 32'h0000_0200);
    outChk("R7 mask blocks 9", 0, 24);
    // Random phase: scoreboard compares every clock
    for (int n = 0; n < 2000; n++) begin
      int sel = $urandom_range(0, 7);
      case (sel)
        0, 1: busWr(8'h40 + 8'($urandom_range(0, 63)), 32'($urandom_range(0, 5)));
        2: begin @(negedge clk); req = {$urandom, $urandom} & {$urandom, $urandom}; end
        3: busWr($urandom_range(0, 1) ? 8'h08 : 8'h0C, $urandom & $urandom);
        4: busWr(8'h1D, 32'($urandom_range(0, 63)) | ($urandom_range(0, 15) == 0 ? 32'h40 : 32'h0));
        5: busWr(8'h1C, 32'($urandom_range(0, 63)) | ($urandom_range(0, 15) == 0 ? 32'h40 : 32'h0));
        6: busWr($urandom_range(0, 1) ? 8'h10 : 8'h14, $urandom & $urandom & $urandom);
        default: begin
          int el, ev;
          @(negedge clk);
          addr = 8'hE0;
          #1;
          expected(el, ev);
          check("R10 random vector read", longint'(rdata), longint'(ev));
        end
      endcase
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule